// File: doc/BRIEF.md
# Banked GPIO Register Controller

The block is the register front end for a large set of general-purpose pins. The pins are split into equal banks. Software reaches every bank through one flat 32-bit register space, using byte addresses, a write strobe and a read data path that is combinational from the address. Each bank holds three things: a direction word, where a 1 leaves the pin as a high-impedance input; an output latch, which changes only through a write-one-to-set alias and a write-one-to-clear alias; and a synchronized copy of the pin levels.

Bank register windows sit at a fixed stride above a small global area. The global area holds a per-16-pin-group enable word, which is kept for a later interrupt stage. Each window also keeps room for trigger and status words, and these read as zero in this version. Set and clear aliases let one writer change single pins without a read-modify-write. The input copy goes through a two-stage synchronizer, so a readback taken right after an output change still shows the old level for two clocks.

Top module: `pinbank_regfile`

## Requirements
- R1: After reset every direction bit is 1, so `pin_oe` is all zero. Every output latch bit is 0 and the global enable word is 0.
- R2: A direction bit of 0 sets the matching `pin_oe` bit to 1 from the clock edge that takes the write. A direction bit of 1 clears it. The direction word reads back as written.
- R3: A write to a bank's set alias (bank offset 0x08) makes each output bit high where the write data bit is 1. The other bits keep their value.
- R4: A write to a bank's clear alias (bank offset 0x0C) makes each output bit low where the write data bit is 1. The other bits keep their value.
- R5: A read of bank offset 0x04 returns the output latch. A write to that offset changes nothing.
- R6: A read of bank offset 0x10 returns the pin levels through a two-flop synchronizer. A change on `pin_in` before clock edge k becomes visible after edge k+1. This holds whatever the direction of the pin.
- R7: Bank b occupies byte addresses 0x10 + 0x28*b up to 0x37 + 0x28*b. Its direction word is at bank offset 0x00. Pin n is bit n%32 of bank n/32 and maps to bit n of `pin_out`, `pin_oe` and `pin_in`.
- R8: Address 0x08 holds the group enable word. It has one bit per 16-pin group (10 bits), can be read and written, and reads zero above bit 9.
- R9: Reads of any other address return zero and writes to them have no effect. This covers unaligned addresses, addresses 0x00 to 0x07 and 0x0C, the set and clear aliases when read, bank offsets 0x14 to 0x24, and addresses past the last bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 160 | Pin levels, asynchronous to `clk` |
| pin_out | output | 160 | Output latch value per pin |
| pin_oe | output | 160 | Driver enable per pin (1 = drive) |

## Verification
Two functions can meet in the same cycle: a write through the set or clear alias, and a readback of the input word for the pins it moves. On the pins the level changes at once, but the synchronized copy lags. The bench changes `pin_in` and reads the input word directly, after one clock and after two clocks. It expects the old level for the first two reads and the new level only for the third. It also reads the input word of output pins just after changing their latch, and judges that the readback follows the driven `pin_in`, not the latch.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
   localparam int unsigned BUS_W      = 32;
   localparam int unsigned OFS_W      = 6;
   localparam int unsigned GROUP_PINS = 16;

   typedef enum logic [OFS_W-1:0] {
      OFS_DIR = 6'h00,
      OFS_OUT = 6'h04,
      OFS_SET = 6'h08,
      OFS_CLR = 6'h0C,
      OFS_IN  = 6'h10
   } bank_ofs_e;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pinbank_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/pinbank_slice.sv
module pinbank_slice
   import pinbank_pkg::*;
#(
   parameter int unsigned BANK_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [BANK_W-1:0] wdata,
   input  logic [BANK_W-1:0] pad_lvl,
   output logic [BUS_W-1:0]  rdata,
   output logic [BANK_W-1:0] drv_val,
   output logic [BANK_W-1:0] drv_en
);
   logic [BANK_W-1:0] dir_q;
   logic [BANK_W-1:0] lat_q;
   logic [BANK_W-1:0] lvl_sync;

   pinbank_sync #(.WIDTH(BANK_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_lvl),
      .q     (lvl_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '1;
         lat_q <= '0;
      end else if (sel && wr) begin
         case (ofs)
            OFS_DIR: dir_q <= wdata;
            OFS_SET: lat_q <= lat_q | wdata;
            OFS_CLR: lat_q <= lat_q & ~wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      if (sel) begin
         case (ofs)
            OFS_DIR: rdata[BANK_W-1:0] = dir_q;
            OFS_OUT: rdata[BANK_W-1:0] = lat_q;
            OFS_IN:  rdata[BANK_W-1:0] = lvl_sync;
            default: rdata = '0;
         endcase
      end
   end

   assign drv_val = lat_q;
   assign drv_en  = ~dir_q;
endmodule

// File: rtl/pinbank_regfile.sv
module pinbank_regfile
   import pinbank_pkg::*;
#(
   parameter int unsigned NUM_BANKS   = 5,
   parameter int unsigned BANK_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned BANK_BASE   = 16,
   parameter int unsigned BANK_STRIDE = 40,
   parameter int unsigned GEN_OFS     = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic                        bus_wr,
   input  logic [31:0]                 bus_wdata,
   output logic [31:0]                 bus_rdata,
   input  logic [NUM_BANKS*BANK_W-1:0] pin_in,
   output logic [NUM_BANKS*BANK_W-1:0] pin_out,
   output logic [NUM_BANKS*BANK_W-1:0] pin_oe
);
   localparam int unsigned NPINS = NUM_BANKS * BANK_W;
   localparam int unsigned GRP_W = (NPINS + GROUP_PINS - 1) / GROUP_PINS;

   if (BANK_W > BUS_W) begin : g_bad_bank_w
      $error("pinbank_regfile: BANK_W wider than the bus");
   end
   if (GRP_W > BUS_W) begin : g_bad_grp_w
      $error("pinbank_regfile: too many groups for one enable word");
   end
   if (BANK_STRIDE > (1 << OFS_W) || BANK_STRIDE < 20 || (BANK_STRIDE % 4) != 0) begin : g_bad_stride
      $error("pinbank_regfile: BANK_STRIDE out of range");
   end
   if (BANK_BASE + NUM_BANKS * BANK_STRIDE > (1 << ADDR_W)) begin : g_bad_map
      $error("pinbank_regfile: banks exceed the address space");
   end
   if (GEN_OFS + 4 > BANK_BASE || (GEN_OFS % 4) != 0) begin : g_bad_gen
      $error("pinbank_regfile: global enable overlaps the banks");
   end

   logic [BUS_W-1:0] bank_rd [NUM_BANKS];
   logic [GRP_W-1:0] grp_en_q;
   logic             gen_hit;

   assign gen_hit = (bus_addr == ADDR_W'(GEN_OFS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                grp_en_q <= '0;
      else if (gen_hit && bus_wr) grp_en_q <= bus_wdata[GRP_W-1:0];
   end

   for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
      localparam int unsigned LO = BANK_BASE + b * BANK_STRIDE;
      logic [ADDR_W:0] rel;
      logic            hit;

      assign rel = {1'b0, bus_addr} - (ADDR_W+1)'(LO);
      assign hit = !rel[ADDR_W] && (rel < (ADDR_W+1)'(BANK_STRIDE)) && (bus_addr[1:0] == 2'b00);

      pinbank_slice #(.BANK_W(BANK_W), .SYNC_STAGES(SYNC_STAGES)) i_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .sel     (hit),
         .wr      (bus_wr),
         .ofs     (rel[OFS_W-1:0]),
         .wdata   (bus_wdata[BANK_W-1:0]),
         .pad_lvl (pin_in[b*BANK_W +: BANK_W]),
         .rdata   (bank_rd[b]),
         .drv_val (pin_out[b*BANK_W +: BANK_W]),
         .drv_en  (pin_oe[b*BANK_W +: BANK_W])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (gen_hit) bus_rdata[GRP_W-1:0] = grp_en_q;
      for (int b = 0; b < int'(NUM_BANKS); b++) bus_rdata = bus_rdata | bank_rd[b];
   end
endmodule

// File: rtl/pinbank_regfile_chk.sv
module pinbank_regfile_chk #(
   parameter int unsigned NUM_BANKS   = 5,
   parameter int unsigned BANK_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned BANK_BASE   = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [ADDR_W-1:0]           bus_addr,
   input logic                        bus_wr,
   input logic [31:0]                 bus_wdata,
   input logic [31:0]                 bus_rdata,
   input logic [NUM_BANKS*BANK_W-1:0] pin_in,
   input logic [NUM_BANKS*BANK_W-1:0] pin_out,
   input logic [NUM_BANKS*BANK_W-1:0] pin_oe
);
   localparam logic [ADDR_W-1:0] A_OUT0 = ADDR_W'(BANK_BASE + 4);
   localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(BANK_BASE + 8);
   localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(BANK_BASE + 12);
   localparam logic [ADDR_W-1:0] A_IN0  = ADDR_W'(BANK_BASE + 16);

   logic [3:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 4'hF) since_rst <= since_rst + 4'd1;
   end

   AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(pin_oe)); // R2
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(pin_out)); // R3
   AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_SET0) |=>
      ((pin_out[BANK_W-1:0] & $past(bus_wdata[BANK_W-1:0])) == $past(bus_wdata[BANK_W-1:0]))); // R3
   AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_CLR0) |=>
      ((pin_out[BANK_W-1:0] & $past(bus_wdata[BANK_W-1:0])) == '0)); // R4
   AST_OUT_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_OUT0) |-> (bus_rdata[BANK_W-1:0] == pin_out[BANK_W-1:0])); // R5
   AST_OUT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_OUT0) |=> ($stable(pin_out) && $stable(pin_oe))); // R5
   AST_LOW_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == '0) |=> ($stable(pin_out) && $stable(pin_oe))); // R9

   if (SYNC_STAGES == 2) begin : g_sync2
      AST_IN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst >= 4'd2 && bus_addr == A_IN0) |->
         (bus_rdata[BANK_W-1:0] == $past(pin_in[BANK_W-1:0], 2))); // R6
   end
endmodule

bind pinbank_regfile pinbank_regfile_chk #(
   .NUM_BANKS   (NUM_BANKS),
   .BANK_W      (BANK_W),
   .ADDR_W      (ADDR_W),
   .BANK_BASE   (BANK_BASE),
   .SYNC_STAGES (SYNC_STAGES)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_in    (pin_in),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe)
);

// File: tb/test_pinbank_regfile.sv
module test_pinbank_regfile;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 5;
   localparam int NP = NB * 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out;
   logic [NP-1:0] pin_oe;

   logic [31:0]   m_dir [NB];
   logic [31:0]   m_out [NB];
   logic [9:0]    m_glob;
   logic [NP-1:0] m_pin;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pinbank_regfile i_pinbank_regfile (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe)
   );

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      int ai = int'(a);
      if (a[1:0] != 2'b00) return '0;
      if (ai == 8) return {22'd0, m_glob};
      if (ai >= 16 && ai < 16 + 40 * NB) begin
         int b = (ai - 16) / 40;
         int o = (ai - 16) % 40;
         case (o)
            0:  return m_dir[b];
            4:  return m_out[b];
            16: return m_pin[b*32 +: 32];
            default: return '0;
         endcase
      end
      return '0;
   endfunction

   task automatic model_write(input logic [7:0] a, input logic [31:0] d);
      int ai = int'(a);
      if (a[1:0] != 2'b00) return;
      if (ai == 8) begin m_glob = d[9:0]; return; end
      if (ai >= 16 && ai < 16 + 40 * NB) begin
         int b = (ai - 16) / 40;
         int o = (ai - 16) % 40;
         case (o)
            0:  m_dir[b] = d;
            8:  m_out[b] = m_out[b] | d;
            12: m_out[b] = m_out[b] & ~d;
            default: ;
         endcase
      end
   endtask

   task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_pins(input string req);
      logic [NP-1:0] e_out, e_oe;
      for (int b = 0; b < NB; b++) begin
         e_out[b*32 +: 32] = m_out[b];
         e_oe[b*32 +: 32]  = ~m_dir[b];
      end
      n_chk++;
      if (pin_out !== e_out || pin_oe !== e_oe) begin
         n_bad++;
         $display("FAIL %s pins actual out=%h oe=%h expected out=%h oe=%h",
                  req, pin_out, pin_oe, e_out, e_oe);
      end
   endtask

   task automatic do_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a);
      bus_wr = 1'b0;
      bus_addr = a;
      #1;
      chk32(req, bus_rdata, exp_read(a));
   endtask

   task automatic set_pins(input logic [NP-1:0] v);
      @(negedge clk);
      pin_in = v;
      @(negedge clk);
      @(negedge clk);
      m_pin = v;
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R1 watchdog actual=timeout expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] old_w;
      void'($urandom(32'h00C0FFEE));
      for (int b = 0; b < NB; b++) begin m_dir[b] = '1; m_out[b] = '0; end
      m_glob = '0;
      m_pin = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1: reset state
      chk_pins("R1");
      for (int b = 0; b < NB; b++) rd_chk("R1 dir", 8'(16 + 40 * b));
      rd_chk("R1 glob", 8'h08);
      rd_chk("R1 out", 8'h14);

      // R2: direction controls driver enable
      do_write(8'h38, 32'h0000FFFF);
      chk_pins("R2");
      rd_chk("R2 readback", 8'h38);
      do_write(8'h38, 32'hF0F0FFFF);
      chk_pins("R2 back to input");

      // R3: set alias
      do_write(8'h40, 32'h00F0000F);
      chk_pins("R3");
      do_write(8'h40, 32'h00000100);
      chk_pins("R3 accumulate");
      rd_chk("R3 latch", 8'h3C);

      // R4: clear alias
      do_write(8'h44, 32'h00000005);
      chk_pins("R4");
      rd_chk("R4 latch", 8'h3C);

      // R5: direct write to output data has no effect
      do_write(8'h3C, 32'hFFFFFFFF);
      chk_pins("R5");
      rd_chk("R5 readback", 8'h3C);

      // R6: synchronizer latency, both directions
      @(negedge clk);
      old_w = m_pin[64 +: 32];
      pin_in[64 +: 32] = 32'hA5A5_5A5A;
      bus_addr = 8'h70; #1;
      chk32("R6 same cycle old", bus_rdata, old_w);
      @(negedge clk); #1;
      chk32("R6 one edge old", bus_rdata, old_w);
      @(negedge clk); #1;
      chk32("R6 two edges new", bus_rdata, 32'hA5A5_5A5A);
      m_pin[64 +: 32] = 32'hA5A5_5A5A;
      do_write(8'h38, 32'h00000000);
      do_write(8'h40, 32'hFFFFFFFF);
      set_pins(m_pin ^ {96'd0, 32'h1234_5678, 32'd0});
      rd_chk("R6 output pin reads level", 8'h48);
      chk_pins("R6 latch unaffected");

      // R7: bank mapping, outer pins
      do_write(8'hB0, 32'h7FFFFFFF);
      do_write(8'hB8, 32'h80000000);
      do_write(8'h18, 32'h00000001);
      do_write(8'h10, 32'hFFFFFFFE);
      chk_pins("R7");
      chk32("R7 pin159", {31'd0, pin_out[159] & pin_oe[159]}, 32'd1);
      chk32("R7 pin0", {31'd0, pin_out[0] & pin_oe[0]}, 32'd1);

      // R8: group enable word
      do_write(8'h08, 32'hFFFFFFFF);
      rd_chk("R8", 8'h08);
      do_write(8'h08, 32'h00000155);
      rd_chk("R8 pattern", 8'h08);

      // R9: holes and aliases
      do_write(8'h00, 32'hFFFFFFFF);
      do_write(8'h0C, 32'hFFFFFFFF);
      do_write(8'hC4, 32'hFFFFFFFF);
      do_write(8'hD8, 32'hFFFFFFFF);
      do_write(8'hB1, 32'hFFFFFFFF);
      do_write(8'h09, 32'h00000000);
      chk_pins("R9 writes ignored");
      rd_chk("R9 glob kept", 8'h08);
      rd_chk("R9 set alias", 8'h18);
      rd_chk("R9 clr alias", 8'h1C);
      rd_chk("R9 irq slot", 8'hC4);
      rd_chk("R9 past end", 8'hFC);
      rd_chk("R9 unaligned", 8'h11);

      // Random phase across R2..R9
      for (int it = 0; it < 600; it++) begin
         logic [7:0] a;
         logic [31:0] d;
         if (it % 60 == 0)
            set_pins({$urandom, $urandom, $urandom, $urandom, $urandom});
         case ($urandom % 4)
            0, 1: a = 8'(16 + 40 * ($urandom % NB) + 4 * ($urandom % 10));
            2:    a = 8'h08;
            default: a = 8'($urandom);
         endcase
         d = $urandom;
         if ($urandom % 2 == 0) begin
            do_write(a, d);
            chk_pins("R3 R4 R2 random");
         end else begin
            @(negedge clk);
            rd_chk("R7 R9 random read", a);
         end
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule